// File: doc/BRIEF.md
# Four-Bit Ripple ALU with Condition Flags and Hex Display

This block is a purely combinational 4-bit arithmetic and logic unit. It is built from identical bit slices that are chained through their carries. Each slice holds one full adder and a four-way output selector. Two control bits condition the operands before they enter the slices. One inverts operand A in every slice. The other inverts operand B in every slice and also feeds the carry into the lowest slice, so the adder computes A + ~B + 1, which is A minus B.

A two-bit select picks the result of every slice: logical AND, logical OR, the adder sum, or set-if-less-than. A four-bit flag nibble reports the following, from its top bit down:
- carry out of the top slice;
- signed overflow;
- the sign of the result;
- whether the result is all zeros.

The top level is a thin board wrapper. It takes the two operands from slide switches and the function code from four active-low push buttons. It shows A, B, the flags and the result as hexadecimal digits on four active-low seven-segment displays. The block holds no state. There is no clock, no register and no state machine, so every output follows its inputs within the same evaluation.

Top module: `alu_board_top`

## Requirements
- R1: The function code is formed from the inverted buttons: pressing `key_n_i[3]` (driving it to 0) asserts A-invert, `key_n_i[2]` asserts B-negate, and `key_n_i[1]`, `key_n_i[0]` give the select bits S1 and S0. With no button pressed, the code is all zeros.
- R2: With select S1S0 = 00, the result is the bitwise AND of the conditioned operands. With no control asserted, this is A AND B.
- R3: With select S1S0 = 01, the result is the bitwise OR of the conditioned operands.
- R4: With select S1S0 = 10, the result is the low 4 bits of A' + B' + Cin, where Cin equals the B-negate bit. With B-negate set, this gives A - B modulo 16.
- R5: With select S1S0 = 11, result bit 0 is the sign bit of A' + B' + Cin XORed with the overflow flag, and result bits 3..1 are 0.
- R6: Flag bit 3 (C) is the carry out of the top slice of A' + B' + Cin, for every select value.
- R7: Flag bit 2 (V) is the carry into the top slice XOR the carry out of it, for every select value.
- R8: Flag bit 1 (N) equals result bit 3, and flag bit 0 (Z) is 1 exactly when all four result bits are 0.
- R9: `hex_d3_o` shows A, `hex_d2_o` shows B, `hex_d1_o` shows the flag nibble and `hex_d0_o` shows the result. Each display bit i drives segment a..g for i = 0..6, and a segment is lit when its bit is 0. The lit segments (gfedcba) for digits 0..F are, in hex: 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R10: A-invert replaces A by its bitwise complement before every operation; for example, A-invert plus B-negate with select 00 gives NOR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sw_a_i | input | 4 | Operand A from slide switches |
| sw_b_i | input | 4 | Operand B from slide switches |
| key_n_i | input | 4 | Active-low buttons: [3] A-invert, [2] B-negate, [1:0] select |
| hex_d3_o | output | 7 | Leftmost display, operand A, active-low segments |
| hex_d2_o | output | 7 | Display showing operand B |
| hex_d1_o | output | 7 | Display showing flags C,V,N,Z |
| hex_d0_o | output | 7 | Rightmost display, result |

## Verification
A broken carry link between slices corrupts the sum digit and the C and V flags in the same evaluation, with no delay. The corruption shows only for operand pairs whose carries reach that link, which is why the stimulus mixes random operands with carry-chain corner cases. A wrong less-than feed or overflow term shows up only in the set-if-less-than result bit. It is most visible at signed boundaries such as -8 against 7. A swapped select or control bit changes the result digit at once for nearly every operand pair.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        SEL_AND = 2'b00,
        SEL_OR  = 2'b01,
        SEL_SUM = 2'b10,
        SEL_SLT = 2'b11
    } slice_sel_e;

    typedef struct packed {
        logic       a_inv;
        logic       b_neg;
        slice_sel_e sel;
    } alu_op_t;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } alu_flags_t;

    localparam int FLAG_W = $bits(alu_flags_t);
    localparam int OP_W   = $bits(alu_op_t);

endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);

    assign s_o = x_i ^ y_i ^ c_i;
    assign c_o = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);

    // R4
    always_comb begin
        fa_count_chk: assert ({c_o, s_o} == 2'(x_i) + 2'(y_i) + 2'(c_i))
            else $error("full adder mismatch");
    end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       cin_i,
    input  logic       less_i,
    input  alu_op_t    op_i,
    output logic       res_o,
    output logic       sum_o,
    output logic       cout_o
);

    logic a_cond;
    logic b_cond;

    assign a_cond = a_i ^ op_i.a_inv;
    assign b_cond = b_i ^ op_i.b_neg;

    alu_full_adder u_fa (
        .x_i (a_cond),
        .y_i (b_cond),
        .c_i (cin_i),
        .s_o (sum_o),
        .c_o (cout_o)
    );

    always_comb begin
        unique case (op_i.sel)
            SEL_AND: res_o = a_cond & b_cond;
            SEL_OR:  res_o = a_cond | b_cond;
            SEL_SUM: res_o = sum_o;
            SEL_SLT: res_o = less_i;
            default: res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  alu_op_t          op_i,
    output logic [WIDTH-1:0] res_o,
    output alu_flags_t       flags_o
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum_v;
    logic             ovf;
    logic             set_lt;

    assign carry[0] = op_i.b_neg;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_in;
        if (i == 0) begin : g_lsb
            assign less_in = set_lt;
        end else begin : g_upper
            assign less_in = 1'b0;
        end
        alu_bit_slice u_slice (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .cin_i  (carry[i]),
            .less_i (less_in),
            .op_i   (op_i),
            .res_o  (res_o[i]),
            .sum_o  (sum_v[i]),
            .cout_o (carry[i+1])
        );
    end

    assign ovf    = carry[TOP] ^ carry[WIDTH];
    assign set_lt = sum_v[TOP] ^ ovf;

    assign flags_o.c = carry[WIDTH];
    assign flags_o.v = ovf;
    assign flags_o.n = res_o[TOP];
    assign flags_o.z = ~|res_o;

    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide_sum;
    assign a_eff    = op_i.a_inv ? ~a_i : a_i;
    assign b_eff    = op_i.b_neg ? ~b_i : b_i;
    assign wide_sum = (WIDTH+1)'(a_eff) + (WIDTH+1)'(b_eff) + (WIDTH+1)'(op_i.b_neg);

    always_comb begin
        // R4
        sum_path_chk: assert (sum_v == wide_sum[WIDTH-1:0])
            else $error("ripple sum mismatch");
        // R6
        carry_out_chk: assert (flags_o.c == wide_sum[WIDTH])
            else $error("carry flag mismatch");
        // R7
        no_overflow_chk: assert (flags_o.v ==
            ((a_eff[TOP] == b_eff[TOP]) && (wide_sum[TOP] != a_eff[TOP])))
            else $error("overflow flag mismatch");
        // R5
        slt_upper_chk: assert (op_i.sel != SEL_SLT || res_o[WIDTH-1:1] == '0)
            else $error("slt upper bits set");
        // R8
        nz_excl_chk: assert (!(flags_o.n && flags_o.z))
            else $error("negative and zero both set");
    end

endmodule

// File: rtl/seg_hex_decoder.sv
module seg_hex_decoder #(
    parameter int SEG_W = 7
) (
    input  logic [3:0]       nib_i,
    output logic [SEG_W-1:0] seg_n_o
);

    logic [SEG_W-1:0] lit;

    always_comb begin
        unique case (nib_i)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h6F;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            4'hF: lit = 7'h71;
            default: lit = '0;
        endcase
    end

    assign seg_n_o = ~lit;

    // R9
    always_comb begin
        seg_min_lit_chk: assert ($countones(~seg_n_o) >= 2)
            else $error("fewer than two segments lit");
    end

endmodule

// File: rtl/alu_board_top.sv
module alu_board_top
    import alu_pkg::*;
#(
    parameter int OPND_W = 4,
    parameter int SEG_W  = 7
) (
    input  logic [OPND_W-1:0] sw_a_i,
    input  logic [OPND_W-1:0] sw_b_i,
    input  logic [OP_W-1:0]   key_n_i,
    output logic [SEG_W-1:0]  hex_d3_o,
    output logic [SEG_W-1:0]  hex_d2_o,
    output logic [SEG_W-1:0]  hex_d1_o,
    output logic [SEG_W-1:0]  hex_d0_o
);

    localparam int DIGITS = 4;

    alu_op_t          op;
    logic [OPND_W-1:0] res;
    alu_flags_t       flags;

    assign op = alu_op_t'(~key_n_i);

    alu_core #(.WIDTH(OPND_W)) u_core (
        .a_i     (sw_a_i),
        .b_i     (sw_b_i),
        .op_i    (op),
        .res_o   (res),
        .flags_o (flags)
    );

    logic [DIGITS-1:0][3:0]       nib;
    logic [DIGITS-1:0][SEG_W-1:0] seg;

    assign nib[3] = 4'(sw_a_i);
    assign nib[2] = 4'(sw_b_i);
    assign nib[1] = flags;
    assign nib[0] = 4'(res);

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        seg_hex_decoder #(.SEG_W(SEG_W)) u_dec (
            .nib_i   (nib[d]),
            .seg_n_o (seg[d])
        );
    end

    assign hex_d3_o = seg[3];
    assign hex_d2_o = seg[2];
    assign hex_d1_o = seg[1];
    assign hex_d0_o = seg[0];

    // R1
    always_comb begin
        idle_and_chk: assert (key_n_i != '1 || res == (sw_a_i & sw_b_i))
            else $error("idle buttons not AND");
    end

endmodule

// File: tb/tb_alu_board_top.sv
`timescale 1ns/1ps
module tb_alu_board_top;

    localparam int WATCHDOG_CYC = 100000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [3:0] sw_a, sw_b, key_n;
    logic [6:0] h3, h2, h1, h0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    alu_board_top dut (
        .sw_a_i   (sw_a),
        .sw_b_i   (sw_b),
        .key_n_i  (key_n),
        .hex_d3_o (h3),
        .hex_d2_o (h2),
        .hex_d1_o (h1),
        .hex_d0_o (h0)
    );

    function automatic logic [6:0] seg_of(input logic [3:0] v);
        logic [6:0] l;
        case (v)
            4'h0: l = 7'h3F; 4'h1: l = 7'h06; 4'h2: l = 7'h5B; 4'h3: l = 7'h4F;
            4'h4: l = 7'h66; 4'h5: l = 7'h6D; 4'h6: l = 7'h7D; 4'h7: l = 7'h07;
            4'h8: l = 7'h7F; 4'h9: l = 7'h6F; 4'hA: l = 7'h77; 4'hB: l = 7'h7C;
            4'hC: l = 7'h39; 4'hD: l = 7'h5E; 4'hE: l = 7'h79; default: l = 7'h71;
        endcase
        return ~l;
    endfunction

    // returns {result, flags C V N Z}; fn = {a_inv, b_neg, s1, s0}
    function automatic logic [7:0] model(input logic [3:0] a, input logic [3:0] b,
                                         input logic [3:0] fn);
        logic [3:0] ap, bp, r;
        logic [4:0] full;
        logic [3:0] low;
        logic       v;
        ap   = fn[3] ? ~a : a;
        bp   = fn[2] ? ~b : b;
        full = {1'b0, ap} + {1'b0, bp} + {4'b0, fn[2]};
        low  = {1'b0, ap[2:0]} + {1'b0, bp[2:0]} + {3'b0, fn[2]};
        v    = low[3] ^ full[4];
        case (fn[1:0])
            2'b00:   r = ap & bp;
            2'b01:   r = ap | bp;
            2'b10:   r = full[3:0];
            default: r = {3'b000, full[3] ^ v};
        endcase
        return {r, full[4], v, r[3], (r == 4'h0)};
    endfunction

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (a=%h b=%h fn=%h)", tag, act, exp,
                     sw_a, sw_b, ~key_n);
        end
    endtask

    task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic [3:0] fn);
        logic [7:0] m;
        string rtag;
        @(posedge clk);
        sw_a  = a;
        sw_b  = b;
        key_n = ~fn;
        @(negedge clk);
        m = model(a, b, fn);
        case (fn[1:0])
            2'b00:   rtag = fn[3] ? "R2 R10 and" : "R2 and";
            2'b01:   rtag = fn[3] ? "R3 R10 or" : "R3 or";
            2'b10:   rtag = fn[3] ? "R4 R10 sum" : "R4 sum";
            default: rtag = "R5 slt";
        endcase
        check("R9 digit A", h3, seg_of(a));
        check("R9 digit B", h2, seg_of(b));
        check(rtag, h0, seg_of(m[7:4]));
        check("R6 R7 R8 flags", h1, seg_of(m[3:0]));
    endtask

    initial begin
        sw_a = '0; sw_b = '0; key_n = '1;
        // R1 idle state: no button pressed -> AND, flags only Z
        @(negedge clk);
        check("R1 idle result", h0, seg_of(4'h0));
        check("R1 idle flags", h1, seg_of(4'h1));
        check("R9 idle A", h3, seg_of(4'h0));

        // directed corners
        apply(4'hC, 4'hA, 4'b0000);   // R2 AND -> 8
        apply(4'hC, 4'hA, 4'b0001);   // R3 OR  -> E
        apply(4'h7, 4'h1, 4'b0010);   // R4 R7 overflow add -> 8, flags 0110
        apply(4'hF, 4'h1, 4'b0010);   // R6 carry out, result 0, flags 1001
        apply(4'h5, 4'h3, 4'b0110);   // R4 subtract -> 2
        apply(4'h3, 4'h5, 4'b0111);   // R5 3<5 -> 1
        apply(4'h5, 4'h3, 4'b0111);   // R5 5<3 -> 0
        apply(4'h8, 4'h7, 4'b0111);   // R5 -8<7 with overflow correction -> 1
        apply(4'h7, 4'h8, 4'b0111);   // R5 7<-8 -> 0
        apply(4'h8, 4'h1, 4'b0110);   // R7 subtract overflow
        apply(4'h5, 4'h5, 4'b0110);   // R8 zero result from subtract
        apply(4'h3, 4'h4, 4'b1100);   // R10 NOR -> 8
        apply(4'h0, 4'h0, 4'b1010);   // R10 inverted A plus 0 -> F

        // exhaustive sweep over function codes with random operands
        void'($urandom(32'd12345));
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] ra, rb, rf;
            ra = 4'($urandom);
            rb = 4'($urandom);
            rf = 4'(i);
            apply(ra, rb, rf);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule